// File: doc/BRIEF.md
# Toggle-handshake single-port RAM

This block is a single-port word memory in which each access is requested by flipping a multi-bit request token rather than by raising a level enable. A requester front end, clocked on the rising edge, takes load and store commands on a valid/ready stream. For each accepted command it inverts its request token and presents the address, the write flag and the write data. The memory core runs on the falling edge and keeps an acknowledge token of the same width. A request is pending exactly when the two tokens differ. On every falling edge the core serves a pending request and then copies the request token into the acknowledge token. It does this copy whether or not an access took place.

Loads return data on a response stream. Stores return no response. The front end accepts a new command only after the previous one has been acknowledged and any load response has been taken. Back-pressure rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the accept edge until the request is acknowledged and the response, if any, has been taken. A response is held with stable data while `rsp_valid` is high and `rsp_ready` is low, and it leaves on the first rising edge with `rsp_ready` high.

Top module: `tgram_top`

## Requirements
- R1: After reset `cmd_ready` is 1, `rsp_valid` is 0, and both tokens are zero, so the memory is idle.
- R2: A store to an address followed by a load from that same address returns the stored word.
- R3: A load response carries the word currently held at the addressed location. Other locations are not disturbed by stores to different addresses.
- R4: A command accepted on rising edge k completes on rising edge k+1. For a store, `cmd_ready` is high again after that edge. For a load, `rsp_valid` is high after that edge.
- R5: An access whose address is not less than DEPTH (default 256) writes nothing and reads nothing, and it is still acknowledged. A load to such an address returns the data of the most recent in-range load.
- R6: `cmd_ready` and `rsp_valid` are never high together. No command is accepted while a request is pending.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response and its data hold unchanged. No new command is accepted until the response is taken.
- R8: Each accepted command sets the request token to the bitwise inverse of its previous value, and the token is otherwise stable. The acknowledge token equals the request token at every rising edge.
- R9: The read-data register keeps its value on every cycle without an in-range read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The front end uses the rising edge and the core uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Front end can take a command |
| cmd_write | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | ADDR_W (9) | Word address; values at or above DEPTH are out of range |
| cmd_wdata | input | DATA_W (32) | Store data |
| rsp_valid | output | 1 | Load data available |
| rsp_ready | input | 1 | Consumer takes the load data |
| rsp_rdata | output | DATA_W (32) | Load data |

## Verification
Suppose the acknowledge token fails to follow the request token, or follows it too early. The front end then either never leaves its wait state or leaves it before the access. At the ports this shows as `cmd_ready` or `rsp_valid` differing from the reference model one rising edge after the accept edge. A wrong read-data register, including one that changes on an out-of-range or store access, shows up in the next load response. Because every load is compared on the cycle it appears, a corrupted memory word shows up at the first load of that address.

// File: rtl/tgram_pkg.sv
package tgram_pkg;
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_WAIT = 2'd1,
    FE_RESP = 2'd2
  } fe_state_e;
endpackage

// File: rtl/tgram_core.sv
module tgram_core #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int TOG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOG_W-1:0]  req_tog,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [TOG_W-1:0]  ack_tog,
  output logic [DATA_W-1:0] rd_q
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pending;
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign pending  = (req_tog != ack_tog);
  assign in_range = ({1'b0, req_addr} < DEPTH_L);
  assign idx      = IDX_W'(req_addr);

  // token follow and read register: falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tog <= '0;
      rd_q    <= '0;
    end else begin
      ack_tog <= req_tog;
      if (pending && in_range && !req_we)
        rd_q <= mem[idx];
    end
  end

  always_ff @(negedge clk) begin
    if (pending && in_range && req_we)
      mem[idx] <= req_wdata;
  end
endmodule

// File: rtl/tgram_front.sv
module tgram_front
  import tgram_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int TOG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  input  logic [TOG_W-1:0]  ack_tog,
  output logic [TOG_W-1:0]  req_tog,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_we,
  output logic [DATA_W-1:0] req_wdata
);
  fe_state_e st_q;

  assign cmd_ready = (st_q == FE_IDLE);
  assign rsp_valid = (st_q == FE_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= FE_IDLE;
      req_tog   <= '0;
      req_addr  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
    end else begin
      unique case (st_q)
        FE_IDLE: begin
          if (cmd_valid) begin
            req_tog   <= ~req_tog;
            req_addr  <= cmd_addr;
            req_we    <= cmd_write;
            req_wdata <= cmd_wdata;
            st_q      <= FE_WAIT;
          end
        end
        FE_WAIT: begin
          if (ack_tog == req_tog)
            st_q <= req_we ? FE_IDLE : FE_RESP;
        end
        FE_RESP: begin
          if (rsp_ready)
            st_q <= FE_IDLE;
        end
        default: st_q <= FE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tgram_top.sv
module tgram_top #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 9,
  parameter int TOG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [TOG_W-1:0]  req_tog;
  logic [TOG_W-1:0]  ack_tog;
  logic [ADDR_W-1:0] req_addr;
  logic              req_we;
  logic [DATA_W-1:0] req_wdata;

  tgram_front #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOG_W(TOG_W)) front_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .ack_tog(ack_tog), .req_tog(req_tog), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata)
  );

  tgram_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOG_W(TOG_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .req_tog(req_tog), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .ack_tog(ack_tog), .rd_q(rsp_rdata)
  );
endmodule

// File: rtl/tgram_chk.sv
module tgram_chk #(
  parameter int DATA_W = 32,
  parameter int TOG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [TOG_W-1:0]  req_tog,
  input logic [TOG_W-1:0]  ack_tog
);
  // R8: an accepted command inverts the request token
  a_r8_token_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (req_tog == ~$past(req_tog)));

  // R8: without an accept the token holds
  a_r8_token_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(req_tog));

  // R8: every request is acknowledged before the next rising edge
  a_r8_acked_by_rise: assert property (@(posedge clk) disable iff (!rst_n)
    req_tog == ack_tog);

  // R6: no command taken while a request is pending
  a_r6_no_accept_pending: assert property (@(negedge clk) disable iff (!rst_n)
    (req_tog != ack_tog) |-> !cmd_ready);

  // R6: ready and response never together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  // R7: stalled response holds with stable data
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind tgram_top tgram_chk #(.DATA_W(DATA_W), .TOG_W(TOG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .req_tog(req_tog), .ack_tog(ack_tog)
);

// File: tb/tgram_top_tb_top.sv
`timescale 1ns/1ps
module tgram_top_tb_top;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [8:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tgram_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  // behavioural reference: 0 idle, 1 waiting, 2 response
  int          m_st = 0;
  logic [31:0] m_mem [int];
  logic [31:0] m_dout = '0;
  bit          m_we = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_dout = '0;
    end else begin
      case (m_st)
        0: if (cmd_valid) begin
             m_we = cmd_write;
             if (int'(cmd_addr) < DEPTH) begin
               if (cmd_write) m_mem[int'(cmd_addr)] = cmd_wdata;
               else m_dout = m_mem.exists(int'(cmd_addr)) ? m_mem[int'(cmd_addr)] : 32'h0;
             end
             m_st = 1;
           end
        1: m_st = m_we ? 0 : 2;
        default: if (rsp_ready) m_st = 0;
      endcase
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, mid low phase
  always begin
    @(negedge clk);
    #5;
    cyc++;
    if (rst_n && !done) begin
      check("R4/R6 cmd_ready", {31'b0, cmd_ready}, {31'b0, m_st == 0});
      check("R4/R7 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_st == 2});
      if (m_st == 2) check("R3/R9 rsp_rdata", rsp_rdata, m_dout);
    end
  end

  task automatic issue(input bit w, input logic [8:0] a, input logic [31:0] d);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk); #1;
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic store(input logic [8:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic load(input logic [8:0] a, input logic [31:0] exp, input int hold, input string req);
    rsp_ready = (hold == 0);
    issue(1'b0, a, 32'h0);
    while (!rsp_valid) @(negedge clk);
    #2;
    check(req, rsp_rdata, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk); #2;
      check("R7 held valid", {31'b0, rsp_valid}, 32'd1);
      check("R7 held data", rsp_rdata, exp);
      check("R7 no accept", {31'b0, cmd_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1 cmd_ready", {31'b0, cmd_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    check("R1 idle after release", {31'b0, cmd_ready}, 32'd1);

    store(9'd5, 32'hA5A5_0001);
    load(9'd5, 32'hA5A5_0001, 0, "R2 write then read");
    store(9'd0, 32'h1111_0000);
    store(9'd255, 32'hFFFF_00FF);
    load(9'd0, 32'h1111_0000, 0, "R3 low boundary");
    load(9'd255, 32'hFFFF_00FF, 0, "R3 high boundary");
    load(9'd5, 32'hA5A5_0001, 0, "R3 untouched word");
    // out of range: store writes nothing, load keeps previous data
    store(9'd256, 32'hDEAD_BEEF);
    load(9'd256, 32'hA5A5_0001, 0, "R5 out-of-range load");
    load(9'd0, 32'h1111_0000, 0, "R5 no alias write at 0");
    load(9'd511, 32'h1111_0000, 2, "R9 data held");
    // back-pressure
    load(9'd255, 32'hFFFF_00FF, 5, "R7 stalled response");
    // overwrite
    store(9'd5, 32'h0000_0BAD);
    store(9'd5, 32'h0000_0600);
    load(9'd5, 32'h0000_0600, 0, "R2 last store wins");
    // pattern sweep
    for (int i = 0; i < 24; i++)
      store(9'(i * 11 % 256), 32'h5000_0000 + 32'(i * 7));
    for (int i = 23; i >= 0; i--)
      load(9'(i * 11 % 256), 32'h5000_0000 + 32'(i * 7), i % 3, "R2 sweep");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule